// File: doc/BRIEF.md
# Host/Co-processor Doorbell and Vectored Interrupt Bridge

This block carries interrupts in both directions between a host processor and a graphics co-processor card. On the co-processor side there are two sources: a vertical-blank tick and a doorbell that the host rings. Each source sets its own sticky pending bit. The co-processor reads these bits through a status register and clears them by writing ones. One local interrupt line is high whenever either bit is pending.

Interrupts toward the host are vectored by hand. Co-processor software first writes a vector number into a vector register. It then writes the trigger register. The trigger copies the vector into a held slot and raises the host IRQ. The IRQ stays high until the host runs an acknowledge cycle. During that cycle the held vector is placed on the vector output, and the IRQ drops on the next clock. Using different vector numbers lets the host dispatch to different service routines. A trigger that arrives while a request is still outstanding is dropped and sets an overrun flag.

The co-processor register port uses a 2-bit address. Address 0 is status, address 1 is the vector register and address 2 is the trigger register. Address 3 reads as zero.

Top module: `irq_bridge`

## Requirements
- R1: After reset, hostIrq, gfxIrq and hostVectorValid are 0, and reads of status (address 0) and vector (address 1) return 0.
- R2: A rising edge on vblankIn sets status bit 0 on the next clock edge. A vblankIn level that stays high does not set the bit again after it has been cleared.
- R3: A one-cycle pulse on hostDoorbellWr sets status bit 1 on the next clock edge.
- R4: gfxIrq is 1 exactly when status bit 0 or status bit 1 is set.
- R5: A write to status clears each of bits 0..2 whose data bit is 1 and leaves bits written 0 unchanged. If a source sets a bit in the same cycle as a write clears it, the bit stays set.
- R6: The vector register at address 1 returns the last value written to it.
- R7: Any write to address 2 while no request is pending raises hostIrq one cycle later, sets status bit 3, and captures the vector register value at that moment. hostIrq then stays high without an acknowledge, whatever is later written to the vector register.
- R8: While hostIrq is high, hostIack makes hostVectorValid 1 and puts the captured vector on hostVector in the same cycle. hostIrq and status bit 3 fall on the next edge. hostIack with no request pending gives hostVectorValid 0 and hostVector 0.
- R9: A trigger write while a request is pending and not being acknowledged is ignored: the captured vector is kept and status bit 2 (overrun) is set.
- R10: A trigger write in the same cycle as an acknowledge starts a new request, and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vblankIn | input | 1 | Vertical-blank level, synchronous to clk |
| hostDoorbellWr | input | 1 | Host doorbell pulse |
| hostIack | input | 1 | Host acknowledge cycle strobe |
| hostIrq | output | 1 | Interrupt request to the host |
| hostVector | output | VEC_W | Vector returned during acknowledge, 0 otherwise |
| hostVectorValid | output | 1 | hostVector carries a vector this cycle |
| gfxWrEn | input | 1 | Co-processor register write enable |
| gfxAddr | input | ADDR_W | Co-processor register address |
| gfxWrData | input | DATA_W | Co-processor write data |
| gfxRdData | output | DATA_W | Co-processor read data (combinational on gfxAddr) |
| gfxIrq | output | 1 | Local interrupt to the co-processor |

## Verification
Status and IRQ results register on the clock edge that samples the stimulus. They are therefore due one cycle after the input. The bench drives an input, waits one rising edge plus a small delay, and then reads. The acknowledge vector and hostVectorValid are combinational in the acknowledge cycle itself, so they are sampled before that cycle's edge. The fall of hostIrq is checked right after the edge. Register reads are combinational on the address and are sampled a short settle time after the address is set.

// File: rtl/irq_bridge_pkg.sv
package irq_bridge_pkg;
  localparam int ADDR_STATUS  = 0;
  localparam int ADDR_VECTOR  = 1;
  localparam int ADDR_TRIGGER = 2;

  localparam int BIT_VBLANK   = 0;
  localparam int BIT_DOORBELL = 1;
  localparam int BIT_OVERRUN  = 2;
  localparam int BIT_BUSY     = 3;
  localparam int STAT_W       = 4;
  localparam int CLR_W        = 3;

  typedef struct packed {
    logic writeVec;   // load software vector register
    logic latchVec;   // capture vector for a new host request
    logic driveVec;   // present captured vector to host
  } dpStrobes_t;
endpackage

// File: rtl/irq_bridge_ctrl.sv
module irq_bridge_ctrl
  import irq_bridge_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vblankIn,
  input  logic              hostDoorbellWr,
  input  logic              hostIack,
  input  logic              gfxWrEn,
  input  logic [ADDR_W-1:0] gfxAddr,
  input  logic [CLR_W-1:0]  clrData,
  output dpStrobes_t        strobes,
  output logic [STAT_W-1:0] statusBits,
  output logic              hostIrq,
  output logic              gfxIrq,
  output logic              ackTaken
);
  logic vblankQ, vblankPend, doorPend, overrunFlag, irqPend;
  logic vblRise, wrStatus, wrVector, wrTrigger, trigAccept, trigReject;
  logic [CLR_W-1:0] clrMask;

  always_comb begin
    vblRise    = vblankIn & ~vblankQ;
    wrStatus   = gfxWrEn && (gfxAddr == ADDR_W'(ADDR_STATUS));
    wrVector   = gfxWrEn && (gfxAddr == ADDR_W'(ADDR_VECTOR));
    wrTrigger  = gfxWrEn && (gfxAddr == ADDR_W'(ADDR_TRIGGER));
    clrMask    = wrStatus ? clrData : '0;
    ackTaken   = hostIack & irqPend;
    trigAccept = wrTrigger & (~irqPend | ackTaken);
    trigReject = wrTrigger & irqPend & ~ackTaken;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vblankQ     <= 1'b0;
      vblankPend  <= 1'b0;
      doorPend    <= 1'b0;
      overrunFlag <= 1'b0;
      irqPend     <= 1'b0;
    end else begin
      vblankQ     <= vblankIn;
      vblankPend  <= vblRise        | (vblankPend  & ~clrMask[BIT_VBLANK]);
      doorPend    <= hostDoorbellWr | (doorPend    & ~clrMask[BIT_DOORBELL]);
      overrunFlag <= trigReject     | (overrunFlag & ~clrMask[BIT_OVERRUN]);
      irqPend     <= trigAccept     | (irqPend     & ~ackTaken);
    end
  end

  always_comb begin
    strobes.writeVec = wrVector;
    strobes.latchVec = trigAccept;
    strobes.driveVec = ackTaken;
    statusBits               = '0;
    statusBits[BIT_VBLANK]   = vblankPend;
    statusBits[BIT_DOORBELL] = doorPend;
    statusBits[BIT_OVERRUN]  = overrunFlag;
    statusBits[BIT_BUSY]     = irqPend;
    hostIrq = irqPend;
    gfxIrq  = vblankPend | doorPend;
  end
endmodule

// File: rtl/irq_bridge_dp.sv
module irq_bridge_dp
  import irq_bridge_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [STAT_W-1:0] statusBits,
  input  logic [ADDR_W-1:0] gfxAddr,
  input  logic [VEC_W-1:0]  vecData,
  output logic [DATA_W-1:0] gfxRdData,
  output logic [VEC_W-1:0]  hostVector
);
  logic [VEC_W-1:0] vecReg, vecHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg  <= '0;
      vecHeld <= '0;
    end else begin
      if (strobes.writeVec) vecReg  <= vecData;
      if (strobes.latchVec) vecHeld <= vecReg;
    end
  end

  always_comb begin
    case (gfxAddr)
      ADDR_W'(ADDR_STATUS): gfxRdData = DATA_W'(statusBits);
      ADDR_W'(ADDR_VECTOR): gfxRdData = DATA_W'(vecReg);
      default:              gfxRdData = '0;
    endcase
    hostVector = strobes.driveVec ? vecHeld : '0;
  end
endmodule

// File: rtl/irq_bridge.sv
module irq_bridge
  import irq_bridge_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vblankIn,
  input  logic              hostDoorbellWr,
  input  logic              hostIack,
  output logic              hostIrq,
  output logic [VEC_W-1:0]  hostVector,
  output logic              hostVectorValid,
  input  logic              gfxWrEn,
  input  logic [ADDR_W-1:0] gfxAddr,
  input  logic [DATA_W-1:0] gfxWrData,
  output logic [DATA_W-1:0] gfxRdData,
  output logic              gfxIrq
);
  dpStrobes_t        strobes;
  logic [STAT_W-1:0] statusBits;

  irq_bridge_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .vblankIn(vblankIn),
    .hostDoorbellWr(hostDoorbellWr), .hostIack(hostIack),
    .gfxWrEn(gfxWrEn), .gfxAddr(gfxAddr), .clrData(gfxWrData[CLR_W-1:0]),
    .strobes(strobes), .statusBits(statusBits), .hostIrq(hostIrq),
    .gfxIrq(gfxIrq), .ackTaken(hostVectorValid)
  );

  irq_bridge_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .statusBits(statusBits),
    .gfxAddr(gfxAddr), .vecData(gfxWrData[VEC_W-1:0]),
    .gfxRdData(gfxRdData), .hostVector(hostVector)
  );
endmodule

// File: rtl/irq_bridge_chk.sv
module irq_bridge_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              vblankIn,
  input logic              hostDoorbellWr,
  input logic              hostIack,
  input logic              hostIrq,
  input logic              hostVectorValid,
  input logic              gfxWrEn,
  input logic [ADDR_W-1:0] gfxAddr,
  input logic              gfxIrq
);
  logic trigWr;
  assign trigWr = gfxWrEn && (gfxAddr == ADDR_W'(2));

  a_r2_vblank_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vblankIn) |=> gfxIrq);
  a_r3_doorbell_sets: assert property (@(posedge clk) disable iff (!rstN)
    hostDoorbellWr |=> gfxIrq);
  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq && !hostIack |=> hostIrq);
  a_r7_trigger_raises: assert property (@(posedge clk) disable iff (!rstN)
    trigWr && !hostIrq |=> hostIrq);
  a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq && hostIack && !trigWr |=> !hostIrq);
  a_r8_valid_needs_irq: assert property (@(posedge clk) disable iff (!rstN)
    hostVectorValid |-> hostIrq && hostIack);
  a_r10_ack_retrigger: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq && hostIack && trigWr |=> hostIrq);
endmodule

bind irq_bridge irq_bridge_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .vblankIn(vblankIn), .hostDoorbellWr(hostDoorbellWr),
  .hostIack(hostIack), .hostIrq(hostIrq), .hostVectorValid(hostVectorValid),
  .gfxWrEn(gfxWrEn), .gfxAddr(gfxAddr), .gfxIrq(gfxIrq)
);

// File: tb/test_irq_bridge.sv
`timescale 1ns/1ps
module test_irq_bridge;
  logic       clk = 1'b0;
  logic       rstN, vblankIn, hostDoorbellWr, hostIack, gfxWrEn;
  logic [1:0] gfxAddr;
  logic [7:0] gfxWrData, gfxRdData, hostVector;
  logic       hostIrq, hostVectorValid, gfxIrq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_bridge i_irq_bridge (
    .clk(clk), .rstN(rstN), .vblankIn(vblankIn), .hostDoorbellWr(hostDoorbellWr),
    .hostIack(hostIack), .hostIrq(hostIrq), .hostVector(hostVector),
    .hostVectorValid(hostVectorValid), .gfxWrEn(gfxWrEn), .gfxAddr(gfxAddr),
    .gfxWrData(gfxWrData), .gfxRdData(gfxRdData), .gfxIrq(gfxIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    gfxWrEn = 1'b1; gfxAddr = a; gfxWrData = d;
    step();
    gfxWrEn = 1'b0; gfxWrData = 8'h00;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    gfxAddr = a; #1; d = gfxRdData;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    regRead(2'd0, d); chk("R1 status", d, 8'h00);
    regRead(2'd1, d); chk("R1 vector", d, 8'h00);
    chk("R1 hostIrq", hostIrq, 0);
    chk("R1 gfxIrq", gfxIrq, 0);
    chk("R1 valid", hostVectorValid, 0);
  endtask

  task automatic t_vblank();
    logic [7:0] d;
    vblankIn = 1'b1; step();
    regRead(2'd0, d); chk("R2 edge sets bit0", d, 8'h01);
    chk("R4 gfxIrq on vblank", gfxIrq, 1);
    step(); step();
    regWrite(2'd0, 8'h01);
    regRead(2'd0, d); chk("R5 w1c bit0", d, 8'h00);
    step(); step(); step();
    regRead(2'd0, d); chk("R2 level no reset", d, 8'h00);
    chk("R4 gfxIrq low", gfxIrq, 0);
    vblankIn = 1'b0; step();
    vblankIn = 1'b1; step();
    regRead(2'd0, d); chk("R2 second edge", d, 8'h01);
    regWrite(2'd0, 8'h01);
    vblankIn = 1'b0; step();
  endtask

  task automatic t_doorbell();
    logic [7:0] d;
    hostDoorbellWr = 1'b1; step(); hostDoorbellWr = 1'b0;
    regRead(2'd0, d); chk("R3 doorbell bit1", d, 8'h02);
    chk("R4 gfxIrq on doorbell", gfxIrq, 1);
    regWrite(2'd0, 8'h05);
    regRead(2'd0, d); chk("R5 zero bits untouched", d, 8'h02);
    regWrite(2'd0, 8'h02);
    regRead(2'd0, d); chk("R5 clear bit1", d, 8'h00);
    // set and clear in one cycle
    hostDoorbellWr = 1'b1; regWrite(2'd0, 8'h02); hostDoorbellWr = 1'b0;
    regRead(2'd0, d); chk("R5 set wins", d, 8'h02);
    regWrite(2'd0, 8'h02);
  endtask

  task automatic t_vector_and_ack();
    logic [7:0] d;
    regWrite(2'd1, 8'h5A);
    regRead(2'd1, d); chk("R6 vector readback", d, 8'h5A);
    regWrite(2'd2, 8'h00);
    chk("R7 irq raised", hostIrq, 1);
    regRead(2'd0, d); chk("R7 busy bit3", d, 8'h08);
    regWrite(2'd1, 8'h33);
    step(); step();
    chk("R7 irq held", hostIrq, 1);
    hostIack = 1'b1; #1;
    chk("R8 valid", hostVectorValid, 1);
    chk("R8 vector captured", hostVector, 8'h5A);
    step(); hostIack = 1'b0;
    chk("R8 irq dropped", hostIrq, 0);
    regRead(2'd0, d); chk("R8 busy cleared", d, 8'h00);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    regWrite(2'd1, 8'h11);
    regWrite(2'd2, 8'h00);
    regWrite(2'd1, 8'h22);
    regWrite(2'd2, 8'h00);
    regRead(2'd0, d); chk("R9 overrun bit2", d, 8'h0C);
    hostIack = 1'b1; #1;
    chk("R9 vector kept", hostVector, 8'h11);
    step(); hostIack = 1'b0;
    chk("R9 irq dropped", hostIrq, 0);
    regWrite(2'd0, 8'h04);
    regRead(2'd0, d); chk("R5 clear overrun", d, 8'h00);
  endtask

  task automatic t_idle_ack();
    hostIack = 1'b1; #1;
    chk("R8 idle valid", hostVectorValid, 0);
    chk("R8 idle vector", hostVector, 8'h00);
    step(); hostIack = 1'b0;
    chk("R8 idle irq", hostIrq, 0);
  endtask

  task automatic t_ack_retrigger();
    logic [7:0] d;
    regWrite(2'd1, 8'h44);
    regWrite(2'd2, 8'h00);
    regWrite(2'd1, 8'h55);
    hostIack = 1'b1; #1;
    chk("R10 old vector", hostVector, 8'h44);
    regWrite(2'd2, 8'h00); hostIack = 1'b0;
    chk("R10 irq again", hostIrq, 1);
    regRead(2'd0, d); chk("R10 no overrun", d, 8'h08);
    hostIack = 1'b1; #1;
    chk("R10 new vector", hostVector, 8'h55);
    step(); hostIack = 1'b0;
    chk("R10 irq dropped", hostIrq, 0);
  endtask

  initial begin
    rstN = 1'b0; vblankIn = 1'b0; hostDoorbellWr = 1'b0; hostIack = 1'b0;
    gfxWrEn = 1'b0; gfxAddr = 2'd0; gfxWrData = 8'h00;
    repeat (3) step();
    rstN = 1'b1; step();
    t_reset();
    t_vblank();
    t_doorbell();
    t_vector_and_ack();
    t_overrun();
    t_idle_ack();
    t_ack_retrigger();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule